// File: doc/BRIEF.md
# Floating-Point Multi-Register Move Sequencer

This block steps through a move of several floating-point registers between an eight-entry file of 96-bit extended values and memory. A 16-bit extension word is sampled on start. It gives the direction of the move and the source of the selection mask. It also gives the bit order used to match mask bits to register numbers. A separate flag says whether the memory side uses predecrement addressing. When the word asks for a dynamic list, the block presents a 3-bit selector for a data register. It takes the low byte of the value that comes back as the mask.

Each selected register moves as a single 96-bit unit on a request/acknowledge port. Only one request is outstanding at a time, and the data passes through unchanged. The register file sits outside the block. The block reads it through a combinational read port and writes it through a write strobe when a load completes. At the end the block pulses `done_o` for one cycle. If a transfer faulted, it also holds an abort flag and the fault code until the next start.

Top module: `fpmm_seq`

## Requirements
- R1: Extension bit 13 chooses direction: 1 stores register-file data to memory (`req_store_o`=1, no register write), 0 loads memory data into the register file (`rf_we_o` on each completed transfer).
- R2: With extension bit 11 clear, the raw mask is extension bits 7:0. With bit 11 set, `dyn_sel_o` carries extension bits 6:4 and the raw mask is `dyn_val_i[7:0]`.
- R3: Bits of `dyn_val_i` above bit 7 have no effect on which registers move.
- R4: With `predec_i`=1 at start, selected registers are visited from 7 down to 0. Otherwise they are visited from 0 up to 7.
- R5: With extension bit 12 set, register n is selected by raw mask bit 7-n. With bit 12 clear, register n is selected by raw mask bit n.
- R6: One request at a time. `req_valid_o` and `req_reg_o` hold until `ack_done_i` or `ack_fault_i`. Store data equals the register-file entry, and load data is written back unchanged.
- R7: A fault ends the sequence in that cycle. `aborted_o`=1 and `fault_code_o` holds the acknowledged code. Registers not yet visited are neither requested nor written.
- R8: An all-zero selection pulses `done_o` in the cycle after start and issues no request.
- R9: A start while busy is ignored: the running order, direction and set of registers are unchanged.
- R10: `done_o` is high for one cycle. `aborted_o` and `fault_code_o` hold until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a move; sampled only when idle |
| ext_word_i | input | 16 | Extension word |
| predec_i | input | 1 | Predecrement addressing in use |
| dyn_sel_o | output | 3 | Data-register selector for a dynamic list |
| dyn_val_i | input | 32 | Value of the selected data register |
| req_valid_o | output | 1 | Transfer request outstanding |
| req_store_o | output | 1 | 1: register to memory, 0: memory to register |
| req_reg_o | output | 3 | Register being transferred |
| req_wdata_o | output | 96 | Store data |
| ack_done_i | input | 1 | Transfer completed |
| ack_fault_i | input | 1 | Transfer faulted |
| ack_code_i | input | 4 | Fault code, valid with ack_fault_i |
| ack_rdata_i | input | 96 | Load data, valid with ack_done_i |
| rf_rd_idx_o | output | 3 | Register-file read index |
| rf_rdata_i | input | 96 | Register-file read data |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_widx_o | output | 3 | Register-file write index |
| rf_wdata_o | output | 96 | Register-file write data |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| aborted_o | output | 1 | Last sequence ended on a fault |
| fault_code_o | output | 4 | Code of that fault |

## Verification
The hardest case to reach is a fault partway through a long list. Some registers have already been written by then, and the rest must stay untouched. The memory model in the bench counts requests and raises the fault on a chosen one. The bench then checks each register-file entry on both sides of the fault. A second hard case is a start that arrives while busy with a conflicting word. The bench pulses start in the middle of a store and confirms that the original order and direction are kept to the end.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } fpmm_state_t;

   localparam int unsigned EXT_DIR_BIT   = 13;
   localparam int unsigned EXT_ORDER_BIT = 12;
   localparam int unsigned EXT_DYN_BIT   = 11;
   localparam int unsigned EXT_DSEL_LSB  = 4;
   localparam int unsigned EXT_DSEL_W    = 3;
endpackage

// File: rtl/fpmm_mask_sel.sv
module fpmm_mask_sel #(
   parameter int unsigned NUM_FP = 8,
   parameter int unsigned DREG_W = 32,
   parameter int unsigned EXT_W  = 16
) (
   input  logic [EXT_W-1:0]  ext_word_i,
   input  logic [DREG_W-1:0] dyn_val_i,
   output logic [NUM_FP-1:0] reg_mask_o
);
   import fpmm_pkg::*;

   logic [NUM_FP-1:0] raw;
   logic              rev;

   assign raw = ext_word_i[EXT_DYN_BIT] ? dyn_val_i[NUM_FP-1:0] : ext_word_i[NUM_FP-1:0];
   assign rev = ext_word_i[EXT_ORDER_BIT];

   for (genvar n = 0; n < NUM_FP; n++) begin : g_map
      assign reg_mask_o[n] = rev ? raw[NUM_FP-1-n] : raw[n];
   end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick #(
   parameter int unsigned NUM_FP = 8,
   localparam int unsigned IDX_W = $clog2(NUM_FP)
) (
   input  logic [NUM_FP-1:0] pend_i,
   input  logic              descend_i,
   output logic [IDX_W-1:0]  idx_o
);
   logic [IDX_W-1:0] lo_idx;
   logic [IDX_W-1:0] hi_idx;

   always_comb begin
      lo_idx = '0;
      for (int i = NUM_FP - 1; i >= 0; i--) begin
         if (pend_i[i]) lo_idx = IDX_W'(i);
      end
   end

   always_comb begin
      hi_idx = '0;
      for (int i = 0; i < NUM_FP; i++) begin
         if (pend_i[i]) hi_idx = IDX_W'(i);
      end
   end

   assign idx_o = descend_i ? hi_idx : lo_idx;
endmodule

// File: rtl/fpmm_seq.sv
module fpmm_seq #(
   parameter int unsigned NUM_FP = 8,
   parameter int unsigned FP_W   = 96,
   parameter int unsigned DREG_W = 32,
   parameter int unsigned EXT_W  = 16,
   parameter int unsigned CODE_W = 4,
   localparam int unsigned IDX_W = $clog2(NUM_FP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [EXT_W-1:0]  ext_word_i,
   input  logic              predec_i,
   output logic [2:0]        dyn_sel_o,
   input  logic [DREG_W-1:0] dyn_val_i,
   output logic              req_valid_o,
   output logic              req_store_o,
   output logic [IDX_W-1:0]  req_reg_o,
   output logic [FP_W-1:0]   req_wdata_o,
   input  logic              ack_done_i,
   input  logic              ack_fault_i,
   input  logic [CODE_W-1:0] ack_code_i,
   input  logic [FP_W-1:0]   ack_rdata_i,
   output logic [IDX_W-1:0]  rf_rd_idx_o,
   input  logic [FP_W-1:0]   rf_rdata_i,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_widx_o,
   output logic [FP_W-1:0]   rf_wdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              aborted_o,
   output logic [CODE_W-1:0] fault_code_o
);
   import fpmm_pkg::*;

   if (NUM_FP != 8) begin : g_chk_num
      $error("fpmm_seq: mask field is one byte, NUM_FP must be 8");
   end
   if (DREG_W < NUM_FP) begin : g_chk_dreg
      $error("fpmm_seq: DREG_W narrower than the mask");
   end
   if (EXT_W < 16) begin : g_chk_ext
      $error("fpmm_seq: extension word needs 16 bits");
   end
   if ((FP_W % 32) != 0) begin : g_chk_fp
      $error("fpmm_seq: FP_W must be whole 32-bit words");
   end

   fpmm_state_t       state_q;
   logic [NUM_FP-1:0] pend_q;
   logic [NUM_FP-1:0] new_mask;
   logic [NUM_FP-1:0] pend_after;
   logic [IDX_W-1:0]  cur_idx;
   logic              store_q;
   logic              desc_q;
   logic              done_q;
   logic              abort_q;
   logic [CODE_W-1:0] code_q;
   logic              in_xfer;
   logic              take_start;

   assign dyn_sel_o = ext_word_i[EXT_DSEL_LSB +: EXT_DSEL_W];

   fpmm_mask_sel #(.NUM_FP(NUM_FP), .DREG_W(DREG_W), .EXT_W(EXT_W)) mask_sel_i (
      .ext_word_i (ext_word_i),
      .dyn_val_i  (dyn_val_i),
      .reg_mask_o (new_mask)
   );

   fpmm_pick #(.NUM_FP(NUM_FP)) pick_i (
      .pend_i    (pend_q),
      .descend_i (desc_q),
      .idx_o     (cur_idx)
   );

   assign in_xfer    = (state_q == ST_XFER);
   assign take_start = (state_q == ST_IDLE) && start_i;
   assign pend_after = pend_q & ~(NUM_FP'(1) << cur_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         store_q <= 1'b0;
         desc_q  <= 1'b0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         code_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (take_start) begin
            store_q <= ext_word_i[EXT_DIR_BIT];
            desc_q  <= predec_i;
            pend_q  <= new_mask;
            abort_q <= 1'b0;
            code_q  <= '0;
            if (new_mask == '0) done_q  <= 1'b1;
            else                state_q <= ST_XFER;
         end else if (in_xfer) begin
            if (ack_fault_i) begin
               abort_q <= 1'b1;
               code_q  <= ack_code_i;
               pend_q  <= '0;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end else if (ack_done_i) begin
               pend_q <= pend_after;
               if (pend_after == '0) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
         end
      end
   end

   assign req_valid_o  = in_xfer;
   assign req_store_o  = store_q;
   assign req_reg_o    = cur_idx;
   assign rf_rd_idx_o  = cur_idx;
   assign req_wdata_o  = rf_rdata_i;
   assign rf_we_o      = in_xfer && ack_done_i && !ack_fault_i && !store_q;
   assign rf_widx_o    = cur_idx;
   assign rf_wdata_o   = ack_rdata_i;
   assign busy_o       = in_xfer;
   assign done_o       = done_q;
   assign aborted_o    = abort_q;
   assign fault_code_o = code_q;

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !ack_done_i && !ack_fault_i) |=> (req_valid_o && $stable(req_reg_o)));

   assert_req_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> pend_q[req_reg_o]);

   assert_write_on_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> !req_store_o);

   assert_fault_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && ack_fault_i) |=> (!busy_o && aborted_o && done_o && !rf_we_o));

   assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && new_mask == '0) |=> (done_o && !busy_o));

   assert_no_grow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ((pend_q & ~$past(pend_q)) == '0));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !req_valid_o));
endmodule

// File: tb/fpmm_seq_tb.sv
module fpmm_seq_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [15:0]  ext_word_i = '0;
   logic         predec_i = 1'b0;
   logic [2:0]   dyn_sel_o;
   logic [31:0]  dyn_val_i;
   logic         req_valid_o, req_store_o;
   logic [2:0]   req_reg_o;
   logic [95:0]  req_wdata_o;
   logic         ack_done_i = 1'b0;
   logic         ack_fault_i = 1'b0;
   logic [3:0]   ack_code_i = '0;
   logic [95:0]  ack_rdata_i = '0;
   logic [2:0]   rf_rd_idx_o;
   logic [95:0]  rf_rdata_i;
   logic         rf_we_o;
   logic [2:0]   rf_widx_o;
   logic [95:0]  rf_wdata_o;
   logic         busy_o, done_o, aborted_o;
   logic [3:0]   fault_code_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [95:0] rf_model [8];
   logic [31:0] dregs [8];
   int          log_n;
   logic [2:0]  log_reg [16];
   logic        log_store [16];
   logic [95:0] log_wdata [16];
   int          req_count;
   int          fault_at = 0;
   logic [3:0]  fault_code = '0;

   always #5 clk = ~clk;

   fpmm_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_word_i(ext_word_i),
      .predec_i(predec_i), .dyn_sel_o(dyn_sel_o), .dyn_val_i(dyn_val_i),
      .req_valid_o(req_valid_o), .req_store_o(req_store_o), .req_reg_o(req_reg_o),
      .req_wdata_o(req_wdata_o), .ack_done_i(ack_done_i), .ack_fault_i(ack_fault_i),
      .ack_code_i(ack_code_i), .ack_rdata_i(ack_rdata_i), .rf_rd_idx_o(rf_rd_idx_o),
      .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_widx_o(rf_widx_o),
      .rf_wdata_o(rf_wdata_o), .busy_o(busy_o), .done_o(done_o),
      .aborted_o(aborted_o), .fault_code_o(fault_code_o)
   );

   assign dyn_val_i  = dregs[dyn_sel_o];
   assign rf_rdata_i = rf_model[rf_rd_idx_o];

   function automatic logic [95:0] init_val(int r);
      return {8'hC0 + 8'(r), 24'h123456, 32'hDEAD0000 + 32'(r), 32'h0BADF00D ^ 32'(r)};
   endfunction

   function automatic logic [95:0] mem_val(int r);
      return {8'h50 + 8'(r), 24'hABCDEF, 32'h77770000 + 32'(r), 32'hFEEDC0DE ^ 32'(r)};
   endfunction

   always @(posedge clk) if (rf_we_o) rf_model[rf_widx_o] <= rf_wdata_o;

   // memory model: answers one cycle after each request appears
   always @(negedge clk) begin
      if (ack_done_i || ack_fault_i) begin
         ack_done_i  = 1'b0;
         ack_fault_i = 1'b0;
      end else if (req_valid_o && rst_n) begin
         req_count++;
         if (log_n < 16) begin
            log_reg[log_n]   = req_reg_o;
            log_store[log_n] = req_store_o;
            log_wdata[log_n] = req_wdata_o;
         end
         log_n++;
         ack_rdata_i = mem_val(int'(req_reg_o));
         if (req_count == fault_at) begin
            ack_fault_i = 1'b1;
            ack_code_i  = fault_code;
         end else begin
            ack_done_i = 1'b1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic reset_rf();
      for (int r = 0; r < 8; r++) rf_model[r] = init_val(r);
      log_n = 0;
      req_count = 0;
   endtask

   task automatic pulse_start(input logic [15:0] w, input logic pd);
      @(negedge clk);
      ext_word_i = w;
      predec_i   = pd;
      start_i    = 1'b1;
      @(negedge clk);
      start_i    = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done_o && n < 200) begin
         @(negedge clk);
         n++;
      end
      check(done_o, req, "done pulse", done_o, 1);
   endtask

   // expected visit list from the requirements (R4, R5)
   task automatic check_order(input logic [7:0] raw, input bit rev, input bit desc,
                              input bit store, input string req);
      int k = 0;
      for (int s = 0; s < 8; s++) begin
         int n = desc ? 7 - s : s;
         bit sel = rev ? raw[7-n] : raw[n];
         if (sel) begin
            check(k < log_n && log_reg[k] == 3'(n), req, "visit order", log_reg[k], n);
            check(log_store[k] == store, "R1", "direction", log_store[k], store);
            if (store)
               check(log_wdata[k] == init_val(n), "R6", "store data", log_wdata[k][31:0], init_val(n));
            else
               check(rf_model[n] == mem_val(n), "R6", "load data", rf_model[n][31:0], mem_val(n));
            k++;
         end else begin
            check(rf_model[n] == init_val(n), req, "unselected untouched", rf_model[n][31:0], init_val(n));
         end
      end
      check(log_n == k, req, "request count", log_n, k);
   endtask

   task automatic t_reset();
      check(!busy_o && !done_o && !req_valid_o && !aborted_o, "R10", "reset idle",
            {busy_o, done_o, req_valid_o, aborted_o}, 0);
   endtask

   task automatic t_static_store_up();
      reset_rf();
      pulse_start(16'h2025, 1'b0);   // store, static, normal mapping, mask 0x25
      wait_done("R2");
      @(negedge clk);
      check_order(8'h25, 0, 0, 1, "R4");
      check(!busy_o && !done_o, "R10", "done single cycle", done_o, 0);
   endtask

   task automatic t_load_predec();
      reset_rf();
      pulse_start(16'h0081, 1'b1);   // load, mask 0x81, walk down
      wait_done("R4");
      @(negedge clk);
      check_order(8'h81, 0, 1, 0, "R4");
   endtask

   task automatic t_reversed();
      reset_rf();
      pulse_start(16'h3003, 1'b0);   // store, bit12 set, mask 0x03 -> regs 7,6
      wait_done("R5");
      @(negedge clk);
      check_order(8'h03, 1, 0, 1, "R5");
      reset_rf();
      pulse_start(16'h10C0, 1'b1);   // load, bit12 set, mask 0xC0 -> regs 0,1, walk down
      wait_done("R5");
      @(negedge clk);
      check_order(8'hC0, 1, 1, 0, "R5");
   endtask

   task automatic t_dynamic();
      reset_rf();
      dregs[5] = 32'hFFFF_FF12;
      pulse_start(16'h28FF & 16'hFFDF, 1'b0); // dynamic, selector 5 (bits 6:4 = 101), low byte ignored
      check(dyn_sel_o == 3'd5, "R2", "selector", dyn_sel_o, 5);
      wait_done("R2");
      @(negedge clk);
      check_order(8'h12, 0, 0, 1, "R3");
   endtask

   task automatic t_zero_mask();
      reset_rf();
      dregs[2] = 32'hABCD_EF00;       // upper bits set, low byte zero
      pulse_start(16'h0820, 1'b0);    // dynamic, selector 2
      check(done_o && !busy_o, "R8", "done one cycle after start", {done_o, busy_o}, 2);
      @(negedge clk);
      check(log_n == 0, "R3", "no request from upper bits", log_n, 0);
      reset_rf();
      pulse_start(16'h2000, 1'b0);
      check(done_o && !req_valid_o, "R8", "static zero mask", {done_o, req_valid_o}, 2);
      @(negedge clk);
      check(log_n == 0, "R8", "no requests", log_n, 0);
   endtask

   task automatic t_fault();
      reset_rf();
      fault_at = 3;
      fault_code = 4'h5;
      pulse_start(16'h00FF, 1'b0);
      wait_done("R7");
      check(aborted_o && fault_code_o == 4'h5, "R7", "abort code", fault_code_o, 5);
      repeat (4) @(negedge clk);
      check(log_n == 3, "R7", "requests stop at fault", log_n, 3);
      check(rf_model[0] == mem_val(0) && rf_model[1] == mem_val(1), "R7", "earlier loads kept",
            rf_model[1][31:0], mem_val(1));
      for (int r = 2; r < 8; r++)
         check(rf_model[r] == init_val(r), "R7", "unvisited untouched", rf_model[r][31:0], init_val(r));
      check(aborted_o && fault_code_o == 4'h5, "R10", "status held", fault_code_o, 5);
      fault_at = 0;
      reset_rf();
      pulse_start(16'h2001, 1'b0);
      check(!aborted_o && fault_code_o == 4'h0, "R10", "start clears status", aborted_o, 0);
      wait_done("R10");
      @(negedge clk);
   endtask

   task automatic t_start_busy();
      reset_rf();
      pulse_start(16'h200F, 1'b0);    // store regs 0..3 upward
      check(busy_o, "R9", "busy after start", busy_o, 1);
      @(negedge clk);
      ext_word_i = 16'h00F0;
      predec_i = 1'b1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done("R9");
      @(negedge clk);
      check_order(8'h0F, 0, 0, 1, "R9");
   endtask

   initial begin
      for (int r = 0; r < 8; r++) dregs[r] = 32'h0;
      reset_rf();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_static_store_up();
      t_load_predec();
      t_reversed();
      t_dynamic();
      t_zero_mask();
      t_fault();
      t_start_busy();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule